// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Low-Level Flag

This block is a first-in first-out buffer whose producer and consumer run on clocks with no fixed relationship. The producer pushes words on its own clock, and the consumer pops them on another. Each side keeps its own position counter. The counters reach the opposite domain only in reflected binary (Gray) form, through two-flop synchronisers. Because of this, a sample caught in mid-change is wrong by at most one count, and the full and empty decisions stay safe.

Each position counter counts in plain binary. A separate register holds its Gray copy. That copy is loaded from the Gray form of the counter's next value, so the two registers always hold the same count and the Gray lines never carry glitches from the binary adder. On the consumer side, the synchronised producer position is converted back to binary. The buffer occupancy is found by subtraction and compared against a threshold input to drive a low-level flag.

Top module: `dual_clock_fifo`

## Requirements
- R1: While its domain's reset is held and in the first cycle after it, `wr_full` is 0; `rd_empty` and `rd_low` are 1.
- R2: Words leave in the order they were accepted. An accepted pop (`rd_en` high while `rd_empty` is 0 at a read-clock edge) presents its word on `rd_data` after that same edge.
- R3: After DEPTH accepted pushes with no pops, `wr_full` rises. A push while `wr_full` is 1 is discarded, and the producer position does not move.
- R4: A pop while `rd_empty` is 1 is discarded: `rd_data` keeps its value and the consumer position does not move.
- R5: `rd_empty` falls a bounded number of read-clock cycles after a push, and rises in the read-clock cycle after the last stored word is popped.
- R6: `rd_low` is 1 exactly when the occupancy seen by the consumer (synchronised producer position minus consumer position, modulo 2·DEPTH) is less than or equal to `low_level`. It is therefore always 1 while `rd_empty` is 1.
- R7: Each Gray position register changes at most one bit per clock and always equals the Gray form of its binary counter.
- R8: `wr_full` falls a bounded number of write-clock cycles after a pop frees a slot.
- R9: Data stays correct after both positions wrap past 2·DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Synchronous active-high reset, producer domain |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| wr_full | output | 1 | Buffer full, producer domain |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Synchronous active-high reset, consumer domain |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Popped word, registered |
| rd_empty | output | 1 | Buffer empty, consumer domain |
| rd_low | output | 1 | Occupancy at or below `low_level` |
| low_level | input | $clog2(DEPTH)+1 | Low-level threshold, consumer domain |

## Verification
The bench fills the buffer to the brim and then pushes one more word. A design that let that push through would overwrite the oldest entry, and the drain would return the wrong sequence. It also pops from an empty buffer and then checks that the next real word comes out intact. A design that moved its position on that pop would hand back a stale slot. The threshold is stepped across the occupancy at 0, at a middle value and at DEPTH, which exposes off-by-one errors in the less-or-equal comparison or in the modular subtraction. Long runs that wrap both positions several times catch full/empty mix-ups at the extra top bit.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int MIN_DEPTH   = 4;
endpackage

// File: rtl/dcfifo_ptr.sv
module dcfifo_ptr #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray,
  output logic [PW-1:0] bin_next,
  output logic [PW-1:0] gray_next
);
  assign bin_next  = bin + PW'(step);
  assign gray_next = bin_next ^ (bin_next >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_next;
      gray <= gray_next;
    end
  end

  assert_gray_onebit_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(gray ^ $past(gray)) <= 1);
  assert_gray_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    gray == (bin ^ (bin >> 1)));
endmodule

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;
  logic [DW-1:0] cells [N];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic                       wr_clk,
  input  logic                       wr_rst,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       wr_full,
  input  logic                       rd_clk,
  input  logic                       rd_rst,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_empty,
  output logic                       rd_low,
  input  logic [$clog2(DEPTH):0]     low_level
);
  import dcfifo_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_FLIP = PW'(3) << (PW - 2);

  initial begin
    if (DEPTH < MIN_DEPTH || (1 << AW) != DEPTH)
      $error("DEPTH must be a power of two, at least %0d", MIN_DEPTH);
  end

  // producer domain
  logic          wr_fire;
  logic [PW-1:0] wbin, wgray, wbin_nx, wgray_nx, rgray_w;
  logic          full_q;

  assign wr_fire = wr_en & ~full_q;

  dcfifo_ptr #(.PW(PW)) u_wptr (
    .clk(wr_clk), .rst(wr_rst), .step(wr_fire),
    .bin(wbin), .gray(wgray), .bin_next(wbin_nx), .gray_next(wgray_nx)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_w)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_rst) full_q <= 1'b0;
    else        full_q <= (wgray_nx == (rgray_w ^ FULL_FLIP));
  end
  assign wr_full = full_q;

  // consumer domain
  logic          rd_fire;
  logic [PW-1:0] rbin, rgray, rbin_nx, rgray_nx, wgray_r, wbin_r, level_nx;
  logic          empty_q, low_q;

  assign rd_fire = rd_en & ~empty_q;

  dcfifo_ptr #(.PW(PW)) u_rptr (
    .clk(rd_clk), .rst(rd_rst), .step(rd_fire),
    .bin(rbin), .gray(rgray), .bin_next(rbin_nx), .gray_next(rgray_nx)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_r)
  );

  always_comb begin
    wbin_r[PW-1] = wgray_r[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_r[i] = wbin_r[i+1] ^ wgray_r[i];
  end

  assign level_nx = wbin_r - rbin_nx;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      empty_q <= 1'b1;
      low_q   <= 1'b1;
    end else begin
      empty_q <= (rgray_nx == wgray_r);
      low_q   <= (level_nx <= low_level);
    end
  end
  assign rd_empty = empty_q;
  assign rd_low   = low_q;

  dcfifo_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_fire), .raddr(rbin[AW-1:0]), .rdata(rd_data)
  );

  // checks
  assert_no_push_when_full_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_full && wr_en) |=> $stable(wbin));
  assert_wr_step_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wbin_nx - wbin) <= PW'(1));
  assert_no_pop_when_empty_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_empty && rd_en) |=> ($stable(rbin) && $stable(rd_data)));
  assert_low_when_empty_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_empty |-> rd_low);
endmodule

// File: tb/dual_clock_fifo_tb.sv
module dual_clock_fifo_tb;
  localparam int  DEPTH     = 8;
  localparam int  DATA_W    = 8;
  localparam int  PW        = $clog2(DEPTH) + 1;
  localparam time WR_PERIOD = 10ns;
  localparam time RD_PERIOD = 14ns;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic wr_full, rd_empty, rd_low;
  logic [PW-1:0] low_level = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DATA_W-1:0] last_out;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  dual_clock_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_low(rd_low),
    .low_level(low_level)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic push(logic [DATA_W-1:0] d);
    @(negedge wr_clk); wr_en = 1; wr_data = d;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic pop(string req, logic [DATA_W-1:0] exp);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    check(req, rd_data, exp);
    last_out = rd_data;
  endtask

  task automatic t_reset();
    check("R1 full", wr_full, 0);
    check("R1 empty", rd_empty, 1);
    check("R1 low", rd_low, 1);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    check("R1 empty after release", rd_empty, 1);
    check("R1 full after release", wr_full, 0);
  endtask

  task automatic t_order();
    push(8'h11); push(8'h22); push(8'h33);
    settle();
    check("R5 empty falls", rd_empty, 0);
    pop("R2 first", 8'h11);
    pop("R2 second", 8'h22);
    pop("R2 third", 8'h33);
    check("R5 empty rises after last pop", rd_empty, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(8'hA0 + 8'(i));
    settle();
    check("R3 full", wr_full, 1);
    push(8'hEE);
    settle();
    check("R3 still full", wr_full, 1);
    pop("R3 oldest kept", 8'hA0);
    settle();
    check("R8 full falls", wr_full, 0);
    for (int i = 1; i < DEPTH; i++) pop("R3 drain", 8'hA0 + 8'(i));
    check("R3 no extra word", rd_empty, 1);
  endtask

  task automatic t_underflow();
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(negedge rd_clk);
    rd_en = 0;
    check("R4 data held", rd_data, last_out);
    push(8'h5A);
    settle();
    pop("R4 pointer held", 8'h5A);
  endtask

  task automatic t_threshold();
    low_level = 2;
    push(8'h01); push(8'h02);
    settle();
    check("R6 level 2 thr 2", rd_low, 1);
    push(8'h03);
    settle();
    check("R6 level 3 thr 2", rd_low, 0);
    low_level = 0;
    settle();
    check("R6 level 3 thr 0", rd_low, 0);
    low_level = PW'(DEPTH);
    settle();
    check("R6 level 3 thr DEPTH", rd_low, 1);
    low_level = 2;
    pop("R6 pop", 8'h01);
    @(negedge rd_clk);
    check("R6 level 2 after pop", rd_low, 1);
    pop("R6 pop", 8'h02);
    pop("R6 pop", 8'h03);
    check("R6 empty implies low", rd_low, 1);
    low_level = 0;
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < DEPTH - 2; i++) push(8'(r * 16 + i));
      for (int i = 0; i < DEPTH - 2; i++) pop("R9 wrap data", 8'(r * 16 + i));
    end
    settle();
    check("R9 empty after wrap", rd_empty, 1);
    check("R9 not full after wrap", wr_full, 0);
  endtask

  initial begin
    repeat (3) @(negedge rd_clk);
    t_reset();
    t_order();
    t_full();
    t_underflow();
    t_threshold();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule